// File: doc/BRIEF.md
# System Clock Source Switch Controller

This controller decides which oscillator drives the system clock: a 32 MHz crystal or a 16 MHz RC oscillator. It also holds the choice of low-speed 32 kHz source, which is either a crystal or an RC oscillator. Software writes a control word that carries a system-source request bit and a low-speed select bit. The controller watches the power-on and stable flags of both fast oscillators. It moves the glitch-free clock mux only when the target oscillator is able to deliver a clean clock. When the target is the crystal, that means the crystal has also stayed stable for a fixed settling window.

The controller runs on the always-running RC clock. The settling window is counted in cycles of that clock, and its length is derived from the RC frequency and the settling time in microseconds (1024 cycles at 16 MHz for 64 µs). A read-only speed bit reports the source that is really in use, and it is kept apart from the request. A pending flag shows that the request and the active source differ. Writing the request back to the active source cancels a pending switch. An exit from deep sleep returns the low-speed select to RC and leaves the system-source request as it was.

Top module: `clk_src_switch`

## Requirements
- R1: After reset the request bit, the mux select, the speed bit and the low-speed select are all 1 (16 MHz RC), and the pending flag is 0.
- R2: A request for the crystal (request bit 0) does not move the mux select while the crystal is unpowered or not stable, and the pending flag reads 1 for as long as the request and the select differ.
- R3: The mux select goes to 0 (crystal) exactly one cycle after the crystal has been powered and stable for SETTLE_US × RC_FREQ_MHZ consecutive cycles, and never earlier.
- R4: If the crystal stable flag drops for even one cycle, the settling count restarts from zero.
- R5: The RC power-up request output is 1 whenever the request bit is 1 and the RC oscillator reports powered down.
- R6: The speed bit (0 = 32 MHz, 1 = 16 MHz) takes the value of the mux select one cycle after the select changes. It keeps its value in every cycle where the mux reports busy.
- R7: The mux select changes only in a cycle where the mux busy input is 0. A switch to RC (select 1) needs the RC oscillator to be powered and stable.
- R8: A write to the low-speed select bit (0 = crystal, 1 = RC) takes effect only while the mux select is 1 (RC). A write in any other cycle leaves the bit unchanged.
- R9: A deep-sleep exit pulse sets the low-speed select to 1, taking priority over a write in the same cycle, and leaves the request bit unchanged.
- R10: Writing the request back to the active source before a commit clears the pending flag, and no switch happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running RC clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_sys_rc | input | 1 | Written request bit: 0 crystal, 1 RC |
| cfg_lf_rc | input | 1 | Written low-speed select: 0 crystal, 1 RC |
| xtal_pwr_on | input | 1 | Crystal oscillator powered |
| xtal_stable | input | 1 | Crystal oscillator stable |
| rc_pwr_on | input | 1 | RC oscillator powered |
| rc_stable | input | 1 | RC oscillator stable |
| mux_busy | input | 1 | Glitch-free mux reports a switch in progress |
| wake_evt | input | 1 | One-cycle pulse on exit from deep sleep |
| req_sys_rc | output | 1 | Readback of the request bit |
| sys_sel_rc | output | 1 | Mux select: 0 crystal, 1 RC |
| speed_16m | output | 1 | Speed status: 0 = 32 MHz, 1 = 16 MHz |
| lf_sel_rc | output | 1 | Low-speed source select: 0 crystal, 1 RC |
| switch_pending | output | 1 | Request differs from the active source |
| rc_power_req | output | 1 | Asks the RC oscillator to power up |

## Verification
The assertions check on every cycle that the select moves only while the mux is idle and only toward a ready target, with the crystal having been stable and powered. They also check that the speed bit follows the select while the mux is idle, that the settling counter never passes its limit, and that the low-speed select changes only through an allowed write or a wake pulse. Some behaviour needs a scenario in the bench: the exact cycle of a crystal commit after the settling window, the restart of the count after a one-cycle drop in the stable flag, a cancelled request, and a write that is ignored. The bench runs these as directed cases and then runs a long random phase checked against its own cycle model.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  typedef enum logic {
    SRC_XTAL = 1'b0,
    SRC_RC   = 1'b1
  } sys_src_e;

  // cycles of a clock of freq_mhz that cover delay_us
  function automatic int unsigned settle_cycles(input int unsigned freq_mhz,
                                                input int unsigned delay_us);
    return freq_mhz * delay_us;
  endfunction

  // target ready check: crystal needs the settled flag, RC needs power and stable
  function automatic logic target_ready(input sys_src_e tgt,
                                        input logic xtal_ok,
                                        input logic rc_ok);
    return (tgt == SRC_XTAL) ? xtal_ok : rc_ok;
  endfunction

endpackage

// File: rtl/clksw_settle_timer.sv
module clksw_settle_timer #(
  parameter int unsigned LIMIT = 1024,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = (cnt_q == CNT_W'(LIMIT));
  assign done     = at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run)      cnt_q <= '0;
    else if (!at_limit) cnt_q <= cnt_q + 1'b1;
  end

  // R4
  settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LIMIT));

  // R4
  settle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/clksw_lf_select.sv
module clksw_lf_select (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_val,
  input  logic on_rc,
  input  logic wake,
  output logic sel_q
);

  logic wr_allowed;
  assign wr_allowed = wr & on_rc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sel_q <= 1'b1;
    else if (wake)       sel_q <= 1'b1;
    else if (wr_allowed) sel_q <= wr_val;
  end

  // R8
  lf_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> ($past(on_rc) || $past(wake)));

  // R9
  lf_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> sel_q);

endmodule

// File: rtl/clksw_commit.sv
module clksw_commit
  import clksw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  sys_src_e req,
  input  logic     xtal_ok,
  input  logic     rc_ok,
  input  logic     mux_busy,
  output sys_src_e sel_q,
  output logic     speed_q,
  output logic     pending,
  output logic     commit_evt
);

  logic tgt_ready;

  assign pending    = (req != sel_q);
  assign tgt_ready  = target_ready(req, xtal_ok, rc_ok);
  assign commit_evt = pending & tgt_ready & ~mux_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sel_q <= SRC_RC;
    else if (commit_evt) sel_q <= req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         speed_q <= 1'b1;
    else if (!mux_busy) speed_q <= sel_q;
  end

  // R7
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> !$past(mux_busy));

  // R10
  sel_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> ($past(req) == sel_q));

  // R6
  speed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mux_busy |=> $stable(speed_q));

  // R6
  speed_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mux_busy |=> (speed_q == $past(sel_q)));

endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import clksw_pkg::*;
#(
  parameter int unsigned RC_FREQ_MHZ = 16,
  parameter int unsigned SETTLE_US   = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_sys_rc,
  input  logic cfg_lf_rc,
  input  logic xtal_pwr_on,
  input  logic xtal_stable,
  input  logic rc_pwr_on,
  input  logic rc_stable,
  input  logic mux_busy,
  input  logic wake_evt,
  output logic req_sys_rc,
  output logic sys_sel_rc,
  output logic speed_16m,
  output logic lf_sel_rc,
  output logic switch_pending,
  output logic rc_power_req
);

  localparam int unsigned SETTLE_CYC = settle_cycles(RC_FREQ_MHZ, SETTLE_US);

  sys_src_e req_q;
  sys_src_e sel;
  logic     xtal_live;
  logic     xtal_settled;
  logic     xtal_ok;
  logic     rc_ok;
  logic     commit_evt;
  logic     on_rc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= SRC_RC;
    else if (cfg_wr) req_q <= sys_src_e'(cfg_sys_rc);
  end

  assign xtal_live = xtal_pwr_on & xtal_stable;
  assign xtal_ok   = xtal_live & xtal_settled;
  assign rc_ok     = rc_pwr_on & rc_stable;
  assign on_rc     = (sel == SRC_RC);

  clksw_settle_timer #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (xtal_live),
    .done  (xtal_settled)
  );

  clksw_commit u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req_q),
    .xtal_ok    (xtal_ok),
    .rc_ok      (rc_ok),
    .mux_busy   (mux_busy),
    .sel_q      (sel),
    .speed_q    (speed_16m),
    .pending    (switch_pending),
    .commit_evt (commit_evt)
  );

  clksw_lf_select u_lf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .wr_val (cfg_lf_rc),
    .on_rc  (on_rc),
    .wake   (wake_evt),
    .sel_q  (lf_sel_rc)
  );

  assign req_sys_rc   = req_q;
  assign sys_sel_rc   = sel;
  assign rc_power_req = req_q & ~rc_pwr_on;

  // R3
  xtal_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_sel_rc) |-> $past(xtal_pwr_on && xtal_stable && xtal_settled));

  // R7
  rc_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_sel_rc) |-> $past(rc_pwr_on && rc_stable));

  // R2
  no_commit_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xtal_live && !req_sys_rc && sys_sel_rc) |=> sys_sel_rc);

  // R9
  wake_keeps_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !cfg_wr) |=> $stable(req_sys_rc));

  // R5
  rc_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sys_rc && !rc_pwr_on) |-> rc_power_req);

endmodule

// File: tb/tb_clk_src_switch.sv
`timescale 1ns/1ps
module tb_clk_src_switch;

  localparam int N = 16 * 64;

  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0, cfg_sys_rc = 1, cfg_lf_rc = 1;
  logic xtal_pwr_on = 0, xtal_stable = 0, rc_pwr_on = 1, rc_stable = 1;
  logic mux_busy = 0, wake_evt = 0;
  logic req_sys_rc, sys_sel_rc, speed_16m, lf_sel_rc, switch_pending, rc_power_req;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  clk_src_switch dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sys_rc(cfg_sys_rc),
    .cfg_lf_rc(cfg_lf_rc), .xtal_pwr_on(xtal_pwr_on), .xtal_stable(xtal_stable),
    .rc_pwr_on(rc_pwr_on), .rc_stable(rc_stable), .mux_busy(mux_busy),
    .wake_evt(wake_evt), .req_sys_rc(req_sys_rc), .sys_sel_rc(sys_sel_rc),
    .speed_16m(speed_16m), .lf_sel_rc(lf_sel_rc), .switch_pending(switch_pending),
    .rc_power_req(rc_power_req)
  );

  // bench cycle model built from the requirements
  logic m_req, m_sel, m_spd, m_lf;
  int   m_run;

  function automatic bit xtal_may_commit(int run, logic pwr, logic stb);
    return pwr && stb && (run >= N);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req <= 1; m_sel <= 1; m_spd <= 1; m_lf <= 1; m_run <= 0;
    end else begin
      bit ready;
      ready = m_req ? (rc_pwr_on && rc_stable)
                    : xtal_may_commit(m_run, xtal_pwr_on, xtal_stable);
      if (m_req != m_sel && ready && !mux_busy) m_sel <= m_req;
      if (!mux_busy) m_spd <= m_sel;
      if (cfg_wr) m_req <= cfg_sys_rc;
      if (wake_evt) m_lf <= 1;
      else if (cfg_wr && m_sel) m_lf <= cfg_lf_rc;
      m_run <= (xtal_pwr_on && xtal_stable) ? ((m_run < N) ? m_run + 1 : m_run) : 0;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chk(string tag, logic act, logic exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_cfg(logic sys, logic lf);
    cfg_wr = 1; cfg_sys_rc = sys; cfg_lf_rc = lf;
    cyc(1);
    cfg_wr = 0;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c10c));
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk("R1 req", req_sys_rc, 1);
    chk("R1 sel", sys_sel_rc, 1);
    chk("R1 speed", speed_16m, 1);
    chk("R1 lf", lf_sel_rc, 1);
    chk("R1 pending", switch_pending, 0);

    // R2 crystal requested while unpowered
    write_cfg(0, 1);
    chk("R2 pending", switch_pending, 1);
    cyc(20);
    chk("R2 sel held", sys_sel_rc, 1);

    // R3 exact settle window
    xtal_pwr_on = 1; xtal_stable = 1;
    cyc(N);
    chk("R3 not early", sys_sel_rc, 1);
    cyc(1);
    chk("R3 commit", sys_sel_rc, 0);
    chk("R6 speed lags", speed_16m, 1);
    cyc(1);
    chk("R6 speed follows", speed_16m, 0);
    chk("R2 pending cleared", switch_pending, 0);

    // R8 low-speed write ignored while on crystal
    write_cfg(0, 0);
    chk("R8 ignored", lf_sel_rc, 1);

    // R7 busy mux blocks the switch back to RC
    mux_busy = 1;
    write_cfg(1, 1);
    cyc(5);
    chk("R7 blocked", sys_sel_rc, 0);
    mux_busy = 0;
    cyc(1);
    chk("R7 commit rc", sys_sel_rc, 1);
    mux_busy = 1;
    cyc(3);
    chk("R6 speed held busy", speed_16m, 0);
    mux_busy = 0;
    cyc(1);
    chk("R6 speed after idle", speed_16m, 1);

    // R8 accepted while on RC
    write_cfg(1, 0);
    chk("R8 accepted", lf_sel_rc, 0);

    // R9 wake over a same-cycle write
    wake_evt = 1; cfg_wr = 1; cfg_sys_rc = 1; cfg_lf_rc = 0;
    cyc(1);
    wake_evt = 0; cfg_wr = 0;
    chk("R9 lf back to rc", lf_sel_rc, 1);
    chk("R9 req kept", req_sys_rc, 1);

    // R5 RC power-up request
    rc_pwr_on = 0;
    #1;
    chk("R5 power req", rc_power_req, 1);
    rc_pwr_on = 1;
    #1;
    chk("R5 power req off", rc_power_req, 0);

    // R4 restart after a one-cycle drop
    xtal_stable = 0;
    cyc(1);
    xtal_stable = 1;
    write_cfg(0, 1);
    cyc(N - 2);
    chk("R4 restart held", sys_sel_rc, 1);
    cyc(2);
    chk("R4 commit after full", sys_sel_rc, 0);

    // R10 cancel before commit
    rc_stable = 0;
    write_cfg(1, 1);
    chk("R10 pending set", switch_pending, 1);
    write_cfg(0, 1);
    chk("R10 pending cleared", switch_pending, 0);
    rc_stable = 1;
    cyc(5);
    chk("R10 no switch", sys_sel_rc, 0);

    // random phase against the model
    for (int i = 0; i < 6000; i++) begin
      bit ok;
      ok = (sys_sel_rc === m_sel) && (speed_16m === m_spd) && (lf_sel_rc === m_lf)
        && (req_sys_rc === m_req) && (switch_pending === (m_req != m_sel))
        && (rc_power_req === (m_req && !rc_pwr_on));
      check(ok, "R3 R6 R7 R8 model",
            {sys_sel_rc, speed_16m, lf_sel_rc, req_sys_rc},
            {m_sel, m_spd, m_lf, m_req});
      cfg_wr     = ($urandom_range(0, 15) == 0);
      cfg_sys_rc = $urandom_range(0, 1);
      cfg_lf_rc  = $urandom_range(0, 1);
      if ($urandom_range(0, 499) == 0) xtal_pwr_on = ~xtal_pwr_on;
      if ($urandom_range(0, 1499) == 0) xtal_stable = ~xtal_stable;
      if ($urandom_range(0, 299) == 0) rc_pwr_on = ~rc_pwr_on;
      if ($urandom_range(0, 299) == 0) rc_stable = ~rc_stable;
      mux_busy = ($urandom_range(0, 3) == 0);
      wake_evt = ($urandom_range(0, 199) == 0);
      if (i % 1500 == 0) begin xtal_pwr_on = 1; xtal_stable = 1; end
      cyc(1);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule